// File: doc/BRIEF.md
# ADC Serial Read-After-Conversion Controller

This block sits on the host side of a 16-bit successive-approximation converter that returns its result over a serial line. When it accepts a start request, it drives the read/convert control low for a short pulse. It then watches the converter's busy flag fall and come back high. Only after that does it produce a burst of data-clock pulses to shift the result in, most significant bit first. The data clock stays idle low at all other times, so no digital edge disturbs the conversion.

The receiver latches on rising edges of its own data clock. The converter only presents the most significant bit after the first falling edge, so each read uses one more pulse than the word width. The sample from the first rising edge is thrown away. The data clock is the system clock divided by a parameter, chosen so that it stays under the converter's maximum data-clock rate. With a 200 MHz system clock and the default half-period of 8 cycles, the data clock runs at 12.5 MHz. The assembled word appears on a parallel output together with a one-cycle strobe. If the busy flag misbehaves, a timeout flags an error and returns the controller to idle.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rc_o` is 1, `dclk_o` is 0, `valid_o` is 0 and `timeout_o` is 0.
- R2: A `start_i` sampled high while idle drives `rc_o` low for exactly PULSE_W system cycles, beginning in the cycle after the sampling edge.
- R3: `dclk_o` has no rising edge before `busy_i` has gone low and then returned high, and it is never high while `busy_i` is low.
- R4: Each read produces exactly DATA_W+1 rising edges on `dclk_o`. Each high phase lasts DCLK_HALF system cycles, and the clock is low once the burst has ended.
- R5: `sdata_i` is captured in the cycle in which `dclk_o` rises. The capture on the first rising edge is discarded, and the next DATA_W captures form `result_o` with the first of them in bit DATA_W-1 (MSB first).
- R6: `valid_o` is high for exactly one system cycle per read, in the cycle after the final bit is captured. `result_o` keeps its value until the next read completes.
- R7: A `start_i` request arriving during the convert pulse, the busy wait, the read burst or the strobe cycle is ignored: it produces no further `rc_o` pulse, and the read in progress completes with the correct word.
- R8: If `busy_i` does not fall, or does not return high, within TIMEOUT_CYC cycles of waiting, `timeout_o` goes to 1 and the controller returns to idle (`rc_o` high, no data clock, no strobe). `timeout_o` clears when the next start request is accepted.
- R9: `cs_n_o` is held at 0 at all times, including during reset.

Requirement R1 is extended to the first cycle after reset because a synchronous reset has no effect before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to start a conversion and read |
| busy_i | input | 1 | Converter busy flag, low during conversion |
| sdata_i | input | 1 | Serial result data from the converter |
| rc_o | output | 1 | Read/convert control; a low pulse starts a conversion |
| cs_n_o | output | 1 | Converter select, active low, held low |
| dclk_o | output | 1 | Gated, discontinuous data clock, idle low |
| result_o | output | DATA_W | Last assembled conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| timeout_o | output | 1 | Set when the busy flag fails to cycle in time |

## Verification
The collision of interest is a new start request arriving in the same system cycle that the result strobe is raised. At that point the last data-clock high phase is still running, so the controller is not yet idle. The bench watches for `valid_o` and raises `start_i` so that the controller samples it in exactly that strobe cycle. It then requires the delivered word to be correct, the strobe to last one cycle, and no second read/convert pulse to appear afterwards. Start requests are also injected in the middle of the busy wait and the read burst. The bench judges these by counting falling edges on `rc_o` and rising edges on `dclk_o` across the whole read.

// File: rtl/adc_rd_pkg.sv
// Package: shared types for the ADC read-after-conversion controller.
// Assumes: nothing; only holds the sequencer state encoding.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,   // waiting for a start request
        S_CONV  = 3'd1,   // read/convert pulse held low
        S_WLOW  = 3'd2,   // waiting for busy to fall
        S_WHIGH = 3'd3,   // waiting for busy to return high
        S_READ  = 3'd4    // data-clock burst running
    } rd_state_t;

endpackage

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq
// Sequences one conversion: accepts a start while idle, pulses the read/convert
// control low, waits for busy to fall and rise, then enables the read burst.
// Assumes: busy_i is synchronous to clk; done_i pulses once at the end of the burst.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int PULSE_W     = 4,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    input  logic done_i,
    output logic rc_o,
    output logic run_o,
    output logic timeout_o
);

    localparam int LIM   = (TIMEOUT_CYC > PULSE_W) ? TIMEOUT_CYC : PULSE_W;
    localparam int CNT_W = $clog2(LIM + 1);

    rd_state_t        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             to_q;

    // State, wait counter and error flag advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) begin
                        st_q <= S_CONV;
                        to_q <= 1'b0;
                    end
                end
                S_CONV: begin
                    if (cnt_q == CNT_W'(PULSE_W - 1)) begin
                        st_q  <= S_WLOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_WLOW: begin
                    if (!busy_i) begin
                        st_q  <= S_WHIGH;
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
                        st_q <= S_IDLE;
                        to_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_WHIGH: begin
                    if (busy_i) begin
                        st_q  <= S_READ;
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
                        st_q <= S_IDLE;
                        to_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_READ: begin
                    if (done_i) st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Outputs decode directly from the state register.
    always_comb begin
        rc_o      = (st_q != S_CONV);
        run_o     = (st_q == S_READ);
        timeout_o = to_q;
    end

    // A convert pulse may only begin from idle (start requests elsewhere are dropped).
    assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_o) |-> $past(st_q) == S_IDLE);

    // A timeout always leaves the controller idle with the control line released.
    assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (st_q == S_IDLE) && rc_o && !run_o);

    // The read burst starts only once busy has come back high.
    assert_read_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> busy_i && ($past(st_q) == S_WHIGH));

endmodule

// File: rtl/adc_rd_dclk.sv
// Module: adc_rd_dclk
// Divides the system clock into a gated data clock of DATA_W+1 pulses while
// run_i is high; flags the cycle before each rising edge and the burst end.
// Assumes: DCLK_HALF >= 2 and chosen so the data clock stays within its rate limit.
module adc_rd_dclk #(
    parameter int DATA_W    = 16,
    parameter int DCLK_HALF = 8,
    parameter int IDX_W     = $clog2(DATA_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic             dclk_o,
    output logic             smp_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);

    localparam int PH_W = (DCLK_HALF > 1) ? $clog2(DCLK_HALF) : 1;

    logic [PH_W-1:0]  ph_q;
    logic [IDX_W-1:0] pulse_q;
    logic             dclk_q;
    logic             ph_end;

    assign ph_end = (ph_q == PH_W'(DCLK_HALF - 1));

    // Phase counter toggles the clock every DCLK_HALF cycles and counts pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ph_q    <= '0;
            pulse_q <= '0;
            dclk_q  <= 1'b0;
        end else if (ph_end) begin
            ph_q   <= '0;
            dclk_q <= ~dclk_q;
            if (dclk_q) pulse_q <= pulse_q + 1'b1;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Strobes for the shifter and the sequencer.
    always_comb begin
        dclk_o = dclk_q;
        idx_o  = pulse_q;
        smp_o  = run_i && !dclk_q && ph_end;
        done_o = run_i && dclk_q && ph_end && (pulse_q == IDX_W'(DATA_W));
    end

    // The burst never exceeds DATA_W+1 pulses.
    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> pulse_q <= IDX_W'(DATA_W));

    // Every high phase lasts more than one system cycle.
    assert_dclk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $rose(dclk_o)) |=> dclk_o);

endmodule

// File: rtl/adc_rd_shift.sv
// Module: adc_rd_shift
// Captures serial data on each sample strobe, drops the first capture and
// assembles DATA_W bits MSB first; loads the result and pulses valid on the last.
// Assumes: idx_i numbers the pulses of the current burst from zero.
module adc_rd_shift #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);

    logic [DATA_W-2:0] sh_q;

    // Shift kept bits in; load the result and strobe on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (smp_i && idx_i != '0) begin
                sh_q <= {sh_q[DATA_W-3:0], sdata_i};
                if (idx_i == IDX_W'(DATA_W)) begin
                    result_o <= {sh_q, sdata_i};
                    valid_o  <= 1'b1;
                end
            end
        end
    end

    // The strobe lasts exactly one cycle.
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // The result only changes together with the strobe.
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

endmodule

// File: rtl/adc_rd_ctrl.sv
// Module: adc_rd_ctrl (top)
// Host-side controller that starts a conversion, waits out the busy period with
// the data clock idle, then reads the serial result with a gated clock burst.
// Assumes: all inputs synchronous to clk; select may stay permanently active.
module adc_rd_ctrl #(
    parameter int DATA_W      = 16,
    parameter int DCLK_HALF   = 8,
    parameter int PULSE_W     = 4,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              sdata_i,
    output logic              rc_o,
    output logic              cs_n_o,
    output logic              dclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              timeout_o
);

    localparam int IDX_W = $clog2(DATA_W + 2);

    logic             run;
    logic             done;
    logic             smp;
    logic [IDX_W-1:0] idx;

    assign cs_n_o = 1'b0;

    adc_rd_seq #(
        .PULSE_W     (PULSE_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .busy_i    (busy_i),
        .done_i    (done),
        .rc_o      (rc_o),
        .run_o     (run),
        .timeout_o (timeout_o)
    );

    adc_rd_dclk #(
        .DATA_W    (DATA_W),
        .DCLK_HALF (DCLK_HALF),
        .IDX_W     (IDX_W)
    ) u_dclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .dclk_o (dclk_o),
        .smp_o  (smp),
        .idx_o  (idx),
        .done_o (done)
    );

    adc_rd_shift #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_i    (smp),
        .idx_i    (idx),
        .sdata_i  (sdata_i),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    // The data clock stays quiet for the whole busy period.
    assert_dclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> !dclk_o);

    // No strobe while the control line is pulsed for a new conversion.
    assert_no_valid_in_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_o |-> !valid_o);

endmodule

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
// Directed bench for adc_rd_ctrl with a behavioural converter model.
module sim_adc_rd_ctrl;

    localparam int W    = 16;
    localparam int HALF = 8;
    localparam int PW   = 3;
    localparam int TO   = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         busy = 1'b1;
    logic         sdata = 1'b1;
    logic         rc_o, cs_n_o, dclk_o, valid_o, timeout_o;
    logic [W-1:0] result_o;

    int n_chk = 0;
    int n_bad = 0;

    adc_rd_ctrl #(
        .DATA_W (W), .DCLK_HALF (HALF), .PULSE_W (PW), .TIMEOUT_CYC (TO)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start), .busy_i (busy),
        .sdata_i (sdata), .rc_o (rc_o), .cs_n_o (cs_n_o), .dclk_o (dclk_o),
        .result_o (result_o), .valid_o (valid_o), .timeout_o (timeout_o)
    );

    always #2.5 clk = ~clk;

    // Monitors, sampled at the falling system-clock edge.
    int rises = 0, rises_busy_lo = 0, valid_cycles = 0, rc_falls = 0;
    int bad_hi = 0, hi_run = 0, rc_run = 0, last_rc_run = 0;
    logic dclk_p = 1'b0, rc_p = 1'b1;
    always @(negedge clk) begin
        if (dclk_o === 1'b1 && dclk_p === 1'b0) rises++;
        if (dclk_o === 1'b1 && !busy) rises_busy_lo++;
        if (dclk_o === 1'b1) hi_run++;
        else begin
            if (dclk_p === 1'b1 && hi_run != HALF) bad_hi++;
            hi_run = 0;
        end
        if (rc_o === 1'b0) rc_run++;
        else begin
            if (rc_p === 1'b0) last_rc_run = rc_run;
            rc_run = 0;
        end
        if (rc_o === 1'b0 && rc_p === 1'b1) rc_falls++;
        if (valid_o === 1'b1) valid_cycles++;
        dclk_p = dclk_o;
        rc_p   = rc_o;
    end

    // Converter model: presents bit W-n after the n-th falling data-clock edge.
    logic [W-1:0] mword = '0;
    int           fall_n = 0;
    always @(negedge dclk_o) begin
        fall_n++;
        if (fall_n >= 1 && fall_n <= W) sdata <= mword[W - fall_n];
        else sdata <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rc_o === 1'b1 && dclk_o === 1'b0 && valid_o === 1'b0 && timeout_o === 1'b0,
            "R1 reset outputs", {rc_o, dclk_o, valid_o, timeout_o}, 4'b1000);
        chk(cs_n_o === 1'b0, "R9 select low in reset", cs_n_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rc_o === 1'b1 && dclk_o === 1'b0 && valid_o === 1'b0,
            "R1 after release", {rc_o, dclk_o, valid_o}, 3'b100);
    endtask

    // One full read; mode 1 injects starts mid-flow, mode 2 on the strobe cycle.
    task automatic t_read(input logic [W-1:0] word, input int conv, input int mode);
        int r0, v0, f0, b0;
        bit seen;
        mword = word; fall_n = 0;
        r0 = rises; v0 = valid_cycles; f0 = rc_falls; b0 = rises_busy_lo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rc_o === 1'b0, "R2 pulse begins next cycle", rc_o, 0);
        chk(timeout_o === 1'b0, "R8 flag cleared by accepted start", timeout_o, 0);
        repeat (2) @(negedge clk);
        busy = 1'b0;
        for (int i = 0; i < conv; i++) begin
            if (mode == 1 && i == conv / 2) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(rises == r0, "R3 no clock before busy returns", rises - r0, 0);
        busy = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (mode == 1 && i == 5 * HALF) start = 1'b1;
            else if (mode == 1) start = 1'b0;
            if (valid_o === 1'b1) seen = 1'b1;
        end
        start = (mode == 2) ? 1'b1 : 1'b0;
        chk(seen, "R6 strobe raised", seen, 1);
        chk(result_o === word, "R5 assembled word", result_o, word);
        @(negedge clk);
        start = 1'b0;
        chk(valid_o === 1'b0, "R6 strobe one cycle", valid_o, 0);
        repeat (3 * HALF) @(negedge clk);
        chk(rises - r0 == W + 1, "R4 pulse count", rises - r0, W + 1);
        chk(bad_hi == 0, "R4 high phase length", bad_hi, 0);
        chk(dclk_o === 1'b0, "R4 clock idle low after burst", dclk_o, 0);
        chk(valid_cycles - v0 == 1, "R6 one strobe per read", valid_cycles - v0, 1);
        chk(result_o === word, "R6 result held", result_o, word);
        chk(last_rc_run == PW, "R2 pulse width", last_rc_run, PW);
        chk(rises_busy_lo == b0, "R3 clock quiet while busy", rises_busy_lo - b0, 0);
        chk(cs_n_o === 1'b0, "R9 select low", cs_n_o, 0);
        if (mode != 0)
            chk(rc_falls - f0 == 1 && rc_o === 1'b1, "R7 extra starts ignored",
                rc_falls - f0, 1);
    endtask

    // Busy never falls (kind 0) or never returns high (kind 1).
    task automatic t_timeout(input int kind);
        int r0, v0;
        r0 = rises; v0 = valid_cycles;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (kind == 1) begin
            repeat (2) @(negedge clk);
            busy = 1'b0;
        end
        repeat (PW + TO + 20) @(negedge clk);
        chk(timeout_o === 1'b1, "R8 flag set", timeout_o, 1);
        chk(rc_o === 1'b1, "R8 control released", rc_o, 1);
        busy = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        chk(rises == r0 && valid_cycles == v0, "R8 returned to idle, no read",
            rises - r0, 0);
        chk(timeout_o === 1'b1, "R8 flag held until next start", timeout_o, 1);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        repeat (4) @(negedge clk);
        t_read(16'hA5C3, 40, 0);
        t_read(16'h0000, 25, 0);
        t_read(16'hFFFF, 60, 0);
        t_read(16'h8001, 30, 0);
        t_read(16'h7FFE, 40, 1);
        t_read(16'h3C96, 40, 2);
        t_timeout(0);
        t_read(16'h1234, 35, 0);
        t_timeout(1);
        t_read(16'hFEDC, 45, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule